// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Unit

This block sits beside a FIFO core and turns the core's fill level into two early-warning flags. It keeps two thresholds: an empty-side offset that the word count is compared against, and a full-side offset that the free-space count is compared against. The flags are active low. Each goes low when its count has reached its offset or dropped below it, and goes high once the count is strictly above the offset.

The thresholds come from a strap that is sampled while master reset is held. The strap picks a default pair and also picks how software may change the pair later. In parallel mode each access takes a whole offset word from the data bus. In serial mode the offsets are built up one bit per clock from a single serial pin. Reading an offset back onto the output bus works in both modes. Every offset access needs the load strobe together with the usual write, read or serial enable, so the same enables can keep driving the FIFO datapath when load is low.

Partial reset restarts the access sequencing and clears the readback bus. It leaves the stored offsets and the chosen mode as they are.

Top module: `afl_offset_unit`

State machines, each held in its own register:
- Access pointer, with states `SEL_EMPTY` and `SEL_FULL`. It moves from `SEL_EMPTY` to `SEL_FULL` and back again on every accepted parallel write or readback. Either reset puts it in `SEL_EMPTY`.
- Serial loader, with states `SH_EMPTY`, `SH_FULL` and `SH_DONE`.
  - `SH_EMPTY` goes to `SH_FULL` on the last bit of the empty offset.
  - `SH_FULL` goes to `SH_DONE` on the last bit of the full offset.
  - `SH_DONE` holds until a reset. Either reset puts the loader in `SH_EMPTY`.

## Requirements
- R1: While master reset is high, the load pin is the strap. A strap of 0 sets both offsets to 127 and picks parallel mode. A strap of 1 sets both offsets to 1023 and picks serial mode.
- R2: Master reset and partial reset each drive the readback bus to zero one clock later, and each returns the access pointer to the empty offset.
- R3: In parallel mode, load and write enable together store the data bus into the offset under the pointer at the clock edge. Writes alternate: empty offset first, then full offset, then empty again.
- R4: Load and read enable together place the offset under the pointer on the readback bus one clock later, in either mode. Writes and readbacks share one pointer, and each accepted access toggles it.
- R5: In serial mode, load and serial enable together shift one bit per clock into the offsets. The first OFS_W bits fill the empty offset, least significant bit first. The next OFS_W bits fill the full offset in the same order.
- R6: After 2×OFS_W serial bits, further serial bits are ignored. A partial reset restarts serial loading at the empty offset.
- R7: Parallel writes have no effect in serial mode. Serial bits have no effect in parallel mode.
- R8: Partial reset keeps both offsets and the programming mode.
- R9: The almost-empty flag is registered, so it follows the counts with one clock of latency. It is 1 when the word count is greater than the empty offset and 0 otherwise. It is 0 while either reset is high.
- R10: The almost-full flag is registered, so it follows the counts with one clock of latency. It is 1 when the free count is greater than the full offset and 0 otherwise. It is 1 while either reset is high.
- R11: With load low, write enable, read enable and serial enable change neither the offsets, nor the readback bus, nor the access pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mst_rst | input | 1 | Master reset, active high, synchronous |
| part_rst | input | 1 | Partial reset, active high, synchronous |
| ld | input | 1 | Load strobe after reset; default/mode strap during master reset |
| ser_en | input | 1 | Serial enable |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| ser_in | input | 1 | Serial offset bit |
| din | input | OFS_W | Parallel offset data |
| used_cnt | input | CNT_W | Words held in the FIFO core |
| free_cnt | input | CNT_W | Free locations in the FIFO core |
| ofs_q | output | OFS_W | Offset readback bus |
| near_empty_n | output | 1 | Almost-empty flag, low when almost empty |
| near_full_n | output | 1 | Almost-full flag, low when almost full |

## Verification
The hardest state to reach from the ports is the serial loader's terminal state. Getting there takes exactly 2×OFS_W accepted serial bits. The stimulus shifts two full words with known patterns, then shifts two more words of all ones. A readback then shows that the stored pair did not change. The shared pointer is covered by mixing writes and readbacks, so that the parity of the pointer shows in which offset comes back. The flag boundaries are covered by setting the counts one below, equal to and one above each programmed offset.

// File: rtl/afl_pkg.sv
package afl_pkg;

    // Offset programming method latched from the strap during master reset
    typedef enum logic {
        PROG_PAR = 1'b0,
        PROG_SER = 1'b1
    } prog_t;

    // Access pointer shared by parallel writes and readbacks
    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } sel_t;

    // Serial loader progress
    typedef enum logic [1:0] {
        SH_EMPTY = 2'd0,
        SH_FULL  = 2'd1,
        SH_DONE  = 2'd2
    } shift_t;

    localparam int DEF_NEAR = 127;
    localparam int DEF_FAR  = 1023;

endpackage

// File: rtl/afl_access_ctrl.sv
module afl_access_ctrl
    import afl_pkg::*;
#(
    parameter int OFS_W = 14
) (
    input  logic   clk,
    input  logic   mst_rst,
    input  logic   part_rst,
    input  logic   ld,
    input  logic   ser_en,
    input  logic   wr_en,
    input  logic   rd_en,
    output prog_t  method,
    output shift_t sh_state,
    output sel_t   rd_sel,
    output logic   shift_e,
    output logic   shift_f,
    output logic   wr_e,
    output logic   wr_f,
    output logic   rd_fire
);

    localparam int BIT_W = (OFS_W > 1) ? $clog2(OFS_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(OFS_W - 1);

    prog_t              method_q;
    sel_t               sel_q, sel_d;
    shift_t             sh_q, sh_d;
    logic [BIT_W-1:0]   bit_q, bit_d;

    logic any_rst, acc_ok, par_req, rd_req, ser_req;

    assign any_rst = mst_rst | part_rst;
    assign acc_ok  = ld & ~any_rst;
    assign par_req = acc_ok & wr_en & (method_q == PROG_PAR);
    assign rd_req  = acc_ok & rd_en;
    assign ser_req = acc_ok & ser_en & (method_q == PROG_SER);

    // State registers
    always_ff @(posedge clk) begin
        if (mst_rst) begin
            method_q <= ld ? PROG_SER : PROG_PAR;
        end
        if (any_rst) begin
            sel_q <= SEL_EMPTY;
            sh_q  <= SH_EMPTY;
            bit_q <= '0;
        end else begin
            sel_q <= sel_d;
            sh_q  <= sh_d;
            bit_q <= bit_d;
        end
    end

    // Pointer next state
    always_comb begin
        sel_d = sel_q;
        unique case (sel_q)
            SEL_EMPTY: if (par_req | rd_req) sel_d = SEL_FULL;
            SEL_FULL:  if (par_req | rd_req) sel_d = SEL_EMPTY;
            default:   sel_d = SEL_EMPTY;
        endcase
    end

    // Serial loader next state
    always_comb begin
        sh_d  = sh_q;
        bit_d = bit_q;
        unique case (sh_q)
            SH_EMPTY: begin
                if (ser_req) begin
                    if (bit_q == LAST_BIT) begin
                        sh_d  = SH_FULL;
                        bit_d = '0;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            SH_FULL: begin
                if (ser_req) begin
                    if (bit_q == LAST_BIT) begin
                        sh_d  = SH_DONE;
                        bit_d = '0;
                    end else begin
                        bit_d = bit_q + 1'b1;
                    end
                end
            end
            SH_DONE: begin
                sh_d  = SH_DONE;
                bit_d = '0;
            end
            default: begin
                sh_d  = SH_DONE;
                bit_d = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        shift_e = ser_req & (sh_q == SH_EMPTY);
        shift_f = ser_req & (sh_q == SH_FULL);
        wr_e    = par_req & (sel_q == SEL_EMPTY);
        wr_f    = par_req & (sel_q == SEL_FULL);
        rd_fire = rd_req;
        rd_sel  = sel_q;
        method  = method_q;
        sh_state = sh_q;
    end

endmodule

// File: rtl/afl_offset_regs.sv
module afl_offset_regs
    import afl_pkg::*;
#(
    parameter int OFS_W = 14
) (
    input  logic             clk,
    input  logic             mst_rst,
    input  logic             part_rst,
    input  logic             strap,
    input  logic             ser_bit,
    input  logic [OFS_W-1:0] din,
    input  logic             shift_e,
    input  logic             shift_f,
    input  logic             wr_e,
    input  logic             wr_f,
    input  logic             rd_fire,
    input  sel_t             rd_sel,
    output logic [OFS_W-1:0] ofs_e,
    output logic [OFS_W-1:0] ofs_f,
    output logic [OFS_W-1:0] rb_q
);

    localparam logic [OFS_W-1:0] NEAR_V = OFS_W'(DEF_NEAR);
    localparam logic [OFS_W-1:0] FAR_V  = OFS_W'(DEF_FAR);

    logic [OFS_W-1:0] dflt;
    assign dflt = strap ? FAR_V : NEAR_V;

    // Empty-side offset: serial shift enters at the top so the first bit lands at bit 0
    always_ff @(posedge clk) begin
        if (mst_rst)      ofs_e <= dflt;
        else if (shift_e) ofs_e <= {ser_bit, ofs_e[OFS_W-1:1]};
        else if (wr_e)    ofs_e <= din;
    end

    // Full-side offset
    always_ff @(posedge clk) begin
        if (mst_rst)      ofs_f <= dflt;
        else if (shift_f) ofs_f <= {ser_bit, ofs_f[OFS_W-1:1]};
        else if (wr_f)    ofs_f <= din;
    end

    // Readback register
    always_ff @(posedge clk) begin
        if (mst_rst | part_rst) rb_q <= '0;
        else if (rd_fire)       rb_q <= (rd_sel == SEL_FULL) ? ofs_f : ofs_e;
    end

endmodule

// File: rtl/afl_flag_cmp.sv
module afl_flag_cmp #(
    parameter int   CNT_W   = 15,
    parameter int   OFS_W   = 14,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [OFS_W-1:0] ofs,
    output logic             flag_n
);

    localparam int CMP_W = (CNT_W > OFS_W) ? CNT_W : OFS_W;

    logic [CMP_W-1:0] cnt_x, ofs_x;
    assign cnt_x = CMP_W'(cnt);
    assign ofs_x = CMP_W'(ofs);

    // Equal counts as "almost", so only strictly above clears the warning
    always_ff @(posedge clk) begin
        if (rst) flag_n <= RST_VAL;
        else     flag_n <= (cnt_x > ofs_x);
    end

endmodule

// File: rtl/afl_offset_unit.sv
module afl_offset_unit
    import afl_pkg::*;
#(
    parameter int OFS_W = 14,
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             mst_rst,
    input  logic             part_rst,
    input  logic             ld,
    input  logic             ser_en,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             ser_in,
    input  logic [OFS_W-1:0] din,
    input  logic [CNT_W-1:0] used_cnt,
    input  logic [CNT_W-1:0] free_cnt,
    output logic [OFS_W-1:0] ofs_q,
    output logic             near_empty_n,
    output logic             near_full_n
);

    prog_t            method_w;
    shift_t           sh_state_w;
    sel_t             rd_sel_w;
    logic             shift_e_w, shift_f_w, wr_e_w, wr_f_w, rd_fire_w;
    logic [OFS_W-1:0] ofs_e_w, ofs_f_w;
    logic             any_rst;

    assign any_rst = mst_rst | part_rst;

    afl_access_ctrl #(.OFS_W(OFS_W)) u_ctrl (
        .clk      (clk),
        .mst_rst  (mst_rst),
        .part_rst (part_rst),
        .ld       (ld),
        .ser_en   (ser_en),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .method   (method_w),
        .sh_state (sh_state_w),
        .rd_sel   (rd_sel_w),
        .shift_e  (shift_e_w),
        .shift_f  (shift_f_w),
        .wr_e     (wr_e_w),
        .wr_f     (wr_f_w),
        .rd_fire  (rd_fire_w)
    );

    afl_offset_regs #(.OFS_W(OFS_W)) u_regs (
        .clk      (clk),
        .mst_rst  (mst_rst),
        .part_rst (part_rst),
        .strap    (ld),
        .ser_bit  (ser_in),
        .din      (din),
        .shift_e  (shift_e_w),
        .shift_f  (shift_f_w),
        .wr_e     (wr_e_w),
        .wr_f     (wr_f_w),
        .rd_fire  (rd_fire_w),
        .rd_sel   (rd_sel_w),
        .ofs_e    (ofs_e_w),
        .ofs_f    (ofs_f_w),
        .rb_q     (ofs_q)
    );

    afl_flag_cmp #(.CNT_W(CNT_W), .OFS_W(OFS_W), .RST_VAL(1'b0)) u_empty_cmp (
        .clk    (clk),
        .rst    (any_rst),
        .cnt    (used_cnt),
        .ofs    (ofs_e_w),
        .flag_n (near_empty_n)
    );

    afl_flag_cmp #(.CNT_W(CNT_W), .OFS_W(OFS_W), .RST_VAL(1'b1)) u_full_cmp (
        .clk    (clk),
        .rst    (any_rst),
        .cnt    (free_cnt),
        .ofs    (ofs_f_w),
        .flag_n (near_full_n)
    );

endmodule

// File: rtl/afl_offset_unit_chk.sv
module afl_offset_unit_chk #(
    parameter int OFS_W = 14,
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             mst_rst,
    input logic             part_rst,
    input logic             ld,
    input logic             ser_en,
    input logic             wr_en,
    input logic             rd_en,
    input logic [CNT_W-1:0] used_cnt,
    input logic [CNT_W-1:0] free_cnt,
    input logic [OFS_W-1:0] ofs_e,
    input logic [OFS_W-1:0] ofs_f,
    input logic             method,
    input logic [1:0]       sh_state,
    input logic             rd_sel,
    input logic [OFS_W-1:0] ofs_q,
    input logic             near_empty_n,
    input logic             near_full_n
);

    localparam int CW = (CNT_W > OFS_W) ? CNT_W : OFS_W;

    p_rb_clear_r2: assert property (@(posedge clk) disable iff (mst_rst)
        part_rst |=> (ofs_q == '0));

    p_ptr_toggle_r4: assert property (@(posedge clk) disable iff (mst_rst || part_rst)
        (ld && rd_en) |=> (rd_sel != $past(rd_sel)));

    p_serial_done_r6: assert property (@(posedge clk) disable iff (mst_rst || part_rst)
        (sh_state == 2'd2) |=> ($stable(ofs_e) && $stable(ofs_f)));

    p_ser_ignores_par_r7: assert property (@(posedge clk) disable iff (mst_rst || part_rst)
        (method && ld && wr_en && !ser_en) |=> ($stable(ofs_e) && $stable(ofs_f)));

    p_prst_keeps_r8: assert property (@(posedge clk) disable iff (mst_rst)
        part_rst |=> ($stable(ofs_e) && $stable(ofs_f) && $stable(method)));

    p_empty_flag_r9: assert property (@(posedge clk) disable iff (mst_rst || part_rst)
        (!mst_rst && !part_rst) |=>
            (near_empty_n == (CW'($past(used_cnt)) > CW'($past(ofs_e)))));

    p_full_flag_r10: assert property (@(posedge clk) disable iff (mst_rst || part_rst)
        (!mst_rst && !part_rst) |=>
            (near_full_n == (CW'($past(free_cnt)) > CW'($past(ofs_f)))));

    p_no_load_r11: assert property (@(posedge clk) disable iff (mst_rst || part_rst)
        !ld |=> ($stable(ofs_e) && $stable(ofs_f) && $stable(ofs_q) && $stable(rd_sel)));

endmodule

bind afl_offset_unit afl_offset_unit_chk #(.OFS_W(OFS_W), .CNT_W(CNT_W)) i_chk (
    .clk          (clk),
    .mst_rst      (mst_rst),
    .part_rst     (part_rst),
    .ld           (ld),
    .ser_en       (ser_en),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .used_cnt     (used_cnt),
    .free_cnt     (free_cnt),
    .ofs_e        (ofs_e_w),
    .ofs_f        (ofs_f_w),
    .method       (method_w),
    .sh_state     (sh_state_w),
    .rd_sel       (rd_sel_w),
    .ofs_q        (ofs_q),
    .near_empty_n (near_empty_n),
    .near_full_n  (near_full_n)
);

// File: tb/test_afl_offset_unit.sv
module test_afl_offset_unit;

    localparam int OFS_W = 14;
    localparam int CNT_W = 15;

    logic             clk = 1'b0;
    logic             mst_rst = 1'b1;
    logic             part_rst = 1'b0;
    logic             ld = 1'b0;
    logic             ser_en = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic             ser_in = 1'b0;
    logic [OFS_W-1:0] din = '0;
    logic [CNT_W-1:0] used_cnt = '0;
    logic [CNT_W-1:0] free_cnt = '0;
    logic [OFS_W-1:0] ofs_q;
    logic             near_empty_n;
    logic             near_full_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    afl_offset_unit #(.OFS_W(OFS_W), .CNT_W(CNT_W)) i_afl_offset_unit (
        .clk          (clk),
        .mst_rst      (mst_rst),
        .part_rst     (part_rst),
        .ld           (ld),
        .ser_en       (ser_en),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .ser_in       (ser_in),
        .din          (din),
        .used_cnt     (used_cnt),
        .free_cnt     (free_cnt),
        .ofs_q        (ofs_q),
        .near_empty_n (near_empty_n),
        .near_full_n  (near_full_n)
    );

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic master_reset(input logic strap);
        mst_rst = 1'b1; ld = strap;
        tick; tick;
        mst_rst = 1'b0; ld = 1'b0;
        tick;
    endtask

    task automatic part_reset;
        part_rst = 1'b1;
        tick;
        part_rst = 1'b0;
    endtask

    task automatic readback(output logic [OFS_W-1:0] v);
        ld = 1'b1; rd_en = 1'b1;
        tick;
        ld = 1'b0; rd_en = 1'b0;
        v = ofs_q;
    endtask

    task automatic par_write(input logic [OFS_W-1:0] v);
        ld = 1'b1; wr_en = 1'b1; din = v;
        tick;
        ld = 1'b0; wr_en = 1'b0;
    endtask

    task automatic ser_word(input logic [OFS_W-1:0] v);
        for (int i = 0; i < OFS_W; i++) begin
            ld = 1'b1; ser_en = 1'b1; ser_in = v[i];
            tick;
        end
        ld = 1'b0; ser_en = 1'b0; ser_in = 1'b0;
    endtask

    task automatic t_strap_defaults;
        logic [OFS_W-1:0] v;
        mst_rst = 1'b1; ld = 1'b0;
        tick; tick;
        check("R9 empty flag low in reset", 32'(near_empty_n), 32'd0);
        check("R10 full flag high in reset", 32'(near_full_n), 32'd1);
        check("R2 readback zero after reset", 32'(ofs_q), 32'd0);
        mst_rst = 1'b0;
        tick;
        readback(v); check("R1 strap0 empty default", 32'(v), 32'd127);
        readback(v); check("R1 strap0 full default", 32'(v), 32'd127);
        master_reset(1'b1);
        readback(v); check("R1 strap1 empty default", 32'(v), 32'd1023);
        readback(v); check("R1 strap1 full default", 32'(v), 32'd1023);
    endtask

    task automatic t_parallel;
        logic [OFS_W-1:0] v;
        master_reset(1'b0);
        par_write(14'd100);
        par_write(14'd2000);
        readback(v); check("R3 parallel empty offset", 32'(v), 32'd100);
        readback(v); check("R3 parallel full offset", 32'(v), 32'd2000);
        par_write(14'd55);
        readback(v); check("R4 shared pointer reads full", 32'(v), 32'd2000);
        readback(v); check("R4 pointer wraps to empty", 32'(v), 32'd55);
    endtask

    task automatic t_serial;
        logic [OFS_W-1:0] v;
        master_reset(1'b1);
        ser_word(14'd6747);
        ser_word(14'd819);
        readback(v); check("R5 serial empty offset", 32'(v), 32'd6747);
        readback(v); check("R5 serial full offset", 32'(v), 32'd819);
        ser_word(14'h3FFF);
        ser_word(14'h3FFF);
        readback(v); check("R6 extra bits ignored empty", 32'(v), 32'd6747);
        readback(v); check("R6 extra bits ignored full", 32'(v), 32'd819);
        par_write(14'd42);
        readback(v); check("R7 parallel write ignored in serial", 32'(v), 32'd6747);
        readback(v); check("R4 readback in serial mode", 32'(v), 32'd819);
        part_reset;
        ser_word(14'd77);
        readback(v); check("R6 serial restarts after partial reset", 32'(v), 32'd77);
        readback(v); check("R8 full offset kept", 32'(v), 32'd819);
    endtask

    task automatic t_par_ignores_serial;
        logic [OFS_W-1:0] v;
        master_reset(1'b0);
        ser_word(14'd5);
        readback(v); check("R7 serial ignored in parallel (empty)", 32'(v), 32'd127);
        readback(v); check("R7 serial ignored in parallel (full)", 32'(v), 32'd127);
    endtask

    task automatic t_partial_reset;
        logic [OFS_W-1:0] v;
        master_reset(1'b0);
        par_write(14'd300);
        par_write(14'd400);
        par_write(14'd500);
        readback(v); check("R4 readback full", 32'(v), 32'd400);
        par_write(14'd510);
        part_reset;
        check("R2 readback cleared by partial reset", 32'(ofs_q), 32'd0);
        readback(v); check("R2 pointer back to empty", 32'(v), 32'd510);
        readback(v); check("R8 full offset kept", 32'(v), 32'd400);
        par_write(14'd600);
        readback(v); check("R8 parallel mode kept (full)", 32'(v), 32'd400);
        readback(v); check("R8 parallel mode kept (empty)", 32'(v), 32'd600);
    endtask

    task automatic t_flags;
        master_reset(1'b0);
        used_cnt = 15'd127; free_cnt = 15'd127;
        tick;
        check("R9 default equal is almost empty", 32'(near_empty_n), 32'd0);
        check("R10 default equal is almost full", 32'(near_full_n), 32'd0);
        used_cnt = 15'd128; free_cnt = 15'd128;
        tick;
        check("R9 default above", 32'(near_empty_n), 32'd1);
        check("R10 default above", 32'(near_full_n), 32'd1);
        par_write(14'd10);
        par_write(14'd20);
        used_cnt = 15'd9; free_cnt = 15'd19;
        tick;
        check("R9 below offset", 32'(near_empty_n), 32'd0);
        check("R10 below offset", 32'(near_full_n), 32'd0);
        used_cnt = 15'd10; free_cnt = 15'd20;
        tick;
        check("R9 equal offset", 32'(near_empty_n), 32'd0);
        check("R10 equal offset", 32'(near_full_n), 32'd0);
        used_cnt = 15'd11; free_cnt = 15'd21;
        tick;
        check("R9 above offset", 32'(near_empty_n), 32'd1);
        check("R10 above offset", 32'(near_full_n), 32'd1);
        used_cnt = 15'd0; free_cnt = 15'd0;
        tick;
    endtask

    task automatic t_no_load;
        logic [OFS_W-1:0] v;
        master_reset(1'b0);
        par_write(14'd77);
        readback(v); check("R4 readback full before idle", 32'(v), 32'd127);
        wr_en = 1'b1; din = 14'd999; tick; wr_en = 1'b0;
        rd_en = 1'b1; tick; rd_en = 1'b0;
        ser_en = 1'b1; ser_in = 1'b1; tick; ser_en = 1'b0; ser_in = 1'b0;
        check("R11 readback unchanged without load", 32'(ofs_q), 32'd127);
        readback(v); check("R11 empty offset and pointer unchanged", 32'(v), 32'd77);
        readback(v); check("R11 full offset unchanged", 32'(v), 32'd127);
    endtask

    initial begin
        tick;
        t_strap_defaults;
        t_parallel;
        t_serial;
        t_par_ignores_serial;
        t_partial_reset;
        t_flags;
        t_no_load;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule